// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus and produces the command sequence the memory needs after power-up. It holds the clock-enable line low and the bus deselected while it waits for the system to report that the supplies and the clock are stable. It then waits a programmable settling time. After that it raises the clock enable and issues the commands in order: a precharge of all banks, a write of the extended mode register that enables the DLL, and a main mode register write that resets the DLL. It then holds a lock window of NOPs, issues a second precharge of all banks and two auto refreshes, and makes a final main mode register write without the DLL reset. Each gap between commands is filled with NOPs.

Burst length, burst type and CAS latency come from input ports and are placed into both main mode register writes. Every wait is a clock-cycle count set by a parameter, so a simulation can shorten the power-up wait. When the last wait has elapsed, the block raises `init_done` and keeps the bus idle with clock enable high. A synchronous reset starts the whole sequence again.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it falls, `cke` is 0, the bus carries Deselect and `init_done` is 0. A reset at any point of the sequence returns the block to this state.
- R2: While `cke` is 0 the bus carries Deselect (`{cs_n,ras_n,cas_n,we_n}` = 1111). `cke` stays 0 for exactly PWRUP_CYC+1 output cycles, counted from the first cycle whose clock edge samples `supplies_ok` high. It stays 0 indefinitely while `supplies_ok` is low.
- R3: The first cycle with `cke` = 1 carries a NOP (0111). The next cycle carries Precharge All (0010) with `addr` = only bit 10 set and `ba` = 0.
- R4: The extended mode register write (0000) has `ba` = 1 and `addr` = 0, so the DLL enable bit A0 = 0 selects the DLL enabled. It follows the first precharge after exactly T_RP_NOPS NOP cycles. Every wait parameter is at least 1.
- R5: The DLL-reset main mode register write follows the extended write after exactly T_MRD_NOPS NOPs. It has `ba` = 0 and `addr` bit 8 = 1, with bits [2:0] = `bl_code`, bit 3 = `interleave` and bits [6:4] = `cl_code`. Every other address bit is 0.
- R6: After the DLL-reset write come exactly DLL_LOCK_NOPS NOP cycles, then a second Precharge All with the same fields as in R3.
- R7: Two Auto Refresh commands (0001, `ba` = 0, `addr` = 0) follow. The first comes T_RP_NOPS NOPs after the second precharge, and the second comes T_RFC_NOPS NOPs after the first.
- R8: T_RFC_NOPS NOPs after the second refresh comes the final main mode register write. It has `ba` = 0, `addr` bits [12:7] = 0, and bits [6:0] encoded as in R5.
- R9: `init_done` is 0 through the final write and the T_MRD_NOPS NOPs after it. It rises on the next cycle and then stays 1, with `cke` = 1 and NOP on the bus, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| supplies_ok | input | 1 | High once supplies and clock are stable |
| bl_code | input | 3 | Burst length code placed in mode bits [2:0] |
| interleave | input | 1 | Burst type placed in mode bit 3 (1 = interleaved) |
| cl_code | input | 3 | CAS latency code placed in mode bits [6:4] |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address lines |
| init_done | output | 1 | High once initialization is complete |

## Verification
The bench sweeps every combination of three burst-length codes, both burst types and three latency codes. For each one it walks the full sequence and measures the exact number of NOP cycles in every gap. A sequencer that is off by one in any wait, or that shortens the DLL lock window, shows up as a command one cycle early or late. Swapped bank bits on the two register writes, a DLL-reset bit left set in the final write, a missing bit 10 on a precharge, or a mode field shifted out of place all show up as a wrong address or bank value. A reset issued inside the lock window must drop `cke` and `init_done` at once, and the run that follows must repeat the whole sequence.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_DESEL = 4'b1111,
        CMD_NOP   = 4'b0111,
        CMD_PRE   = 4'b0010,
        CMD_REF   = 4'b0001,
        CMD_MRS   = 4'b0000
    } cmd_e;

    typedef enum logic [3:0] {
        ST_PWR_WAIT,
        ST_CKE_ON,
        ST_PRE_A,
        ST_EXT_MRS,
        ST_DLL_RST,
        ST_PRE_B,
        ST_REF_A,
        ST_REF_B,
        ST_MODE_RUN,
        ST_READY
    } step_e;

    // Low seven address bits of a main mode register write
    typedef struct packed {
        logic [2:0] cl;
        logic       interleave;
        logic [2:0] bl;
    } mode_bits_t;

    localparam int MODE_LO_W    = 7;
    localparam int DLL_RST_BIT  = 8;
    localparam int ALL_BANK_BIT = 10;

    function automatic step_e next_step(step_e s);
        case (s)
            ST_PWR_WAIT: return ST_CKE_ON;
            ST_CKE_ON:   return ST_PRE_A;
            ST_PRE_A:    return ST_EXT_MRS;
            ST_EXT_MRS:  return ST_DLL_RST;
            ST_DLL_RST:  return ST_PRE_B;
            ST_PRE_B:    return ST_REF_A;
            ST_REF_A:    return ST_REF_B;
            ST_REF_B:    return ST_MODE_RUN;
            default:     return ST_READY;
        endcase
    endfunction

    function automatic logic is_cmd_step(step_e s);
        return !(s inside {ST_PWR_WAIT, ST_CKE_ON, ST_READY});
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign last = (count == CNT_W'(1));

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0)); // R4
endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
    import ddr_init_pkg::*;
#(
    parameter int PWRUP_CYC     = 40000,
    parameter int T_RP_NOPS     = 3,
    parameter int T_MRD_NOPS    = 2,
    parameter int T_RFC_NOPS    = 14,
    parameter int DLL_LOCK_NOPS = 200,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supplies_ok,
    input  logic             tmr_last,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output step_e            step,
    output logic             issue
);
    logic  pending, pend_n;
    step_e nxt;

    function automatic logic [CNT_W-1:0] gap_after(step_e s);
        case (s)
            ST_PRE_A, ST_PRE_B:    return CNT_W'(T_RP_NOPS);
            ST_EXT_MRS, ST_MODE_RUN: return CNT_W'(T_MRD_NOPS);
            ST_DLL_RST:            return CNT_W'(DLL_LOCK_NOPS);
            default:               return CNT_W'(T_RFC_NOPS);
        endcase
    endfunction

    always_comb begin
        nxt      = step;
        pend_n   = pending;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (step)
            ST_PWR_WAIT: begin
                if (!supplies_ok) begin
                    pend_n = 1'b1;
                end else if (pending) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(PWRUP_CYC);
                    pend_n   = 1'b0;
                end else if (tmr_last) begin
                    nxt    = ST_CKE_ON;
                    pend_n = 1'b1;
                end
            end
            ST_CKE_ON: nxt = ST_PRE_A;
            ST_READY:  nxt = ST_READY;
            default: begin
                if (pending) begin
                    tmr_load = 1'b1;
                    tmr_val  = gap_after(step);
                    pend_n   = 1'b0;
                end else if (tmr_last) begin
                    nxt    = next_step(step);
                    pend_n = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= ST_PWR_WAIT;
            pending <= 1'b1;
        end else begin
            step    <= nxt;
            pending <= pend_n;
        end
    end

    assign issue = pending && is_cmd_step(step);

    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (step == $past(step) || step == next_step($past(step)))); // R5
    AST_WAIT_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        (step == ST_PWR_WAIT && !supplies_ok) |=> (step == ST_PWR_WAIT)); // R2
endmodule

// File: rtl/ddr_cmd_encoder.sv
module ddr_cmd_encoder
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  step_e             step,
    input  logic              issue,
    input  mode_bits_t        mode,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    cmd_e              cmd_n, cmd_q;
    logic [BA_W-1:0]   ba_n;
    logic [ADDR_W-1:0] addr_n;
    logic              cke_n, done_n;

    always_comb begin
        cmd_n  = CMD_NOP;
        ba_n   = '0;
        addr_n = '0;
        cke_n  = 1'b1;
        done_n = 1'b0;
        case (step)
            ST_PWR_WAIT: begin
                cke_n = 1'b0;
                cmd_n = CMD_DESEL;
            end
            ST_READY: done_n = 1'b1;
            default: begin
                if (issue) begin
                    case (step)
                        ST_PRE_A, ST_PRE_B: begin
                            cmd_n = CMD_PRE;
                            addr_n[ALL_BANK_BIT] = 1'b1;
                        end
                        ST_EXT_MRS: begin
                            cmd_n = CMD_MRS;
                            ba_n  = BA_W'(1);
                        end
                        ST_DLL_RST: begin
                            cmd_n = CMD_MRS;
                            addr_n[MODE_LO_W-1:0] = mode;
                            addr_n[DLL_RST_BIT]   = 1'b1;
                        end
                        ST_MODE_RUN: begin
                            cmd_n = CMD_MRS;
                            addr_n[MODE_LO_W-1:0] = mode;
                        end
                        default: cmd_n = CMD_REF;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke       <= 1'b0;
            cmd_q     <= CMD_DESEL;
            ba        <= '0;
            addr      <= '0;
            init_done <= 1'b0;
        end else begin
            cke       <= cke_n;
            cmd_q     <= cmd_n;
            ba        <= ba_n;
            addr      <= addr_n;
            init_done <= done_n;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

    AST_DESEL_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
        !cke |-> cs_n); // R2
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_PRE) |-> addr[ALL_BANK_BIT]); // R3
    AST_MRS_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_MRS) |-> (ba <= BA_W'(1) && addr[7] == 1'b0
                                && addr[ADDR_W-1:9] == '0)); // R8
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cke && cmd_q == CMD_NOP)); // R9
endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int BA_W          = 2,
    parameter int PWRUP_CYC     = 40000,
    parameter int T_RP_NOPS     = 3,
    parameter int T_MRD_NOPS    = 2,
    parameter int T_RFC_NOPS    = 14,
    parameter int DLL_LOCK_NOPS = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supplies_ok,
    input  logic [2:0]        bl_code,
    input  logic              interleave,
    input  logic [2:0]        cl_code,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int WAIT_MAX = max2(max2(PWRUP_CYC, DLL_LOCK_NOPS),
                                   max2(max2(T_RP_NOPS, T_MRD_NOPS), T_RFC_NOPS));
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);

    logic             tmr_load, tmr_last, issue;
    logic [CNT_W-1:0] tmr_val;
    step_e            step;
    mode_bits_t       mode;

    assign mode = '{cl: cl_code, interleave: interleave, bl: bl_code};

    ddr_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    ddr_init_fsm #(
        .PWRUP_CYC     (PWRUP_CYC),
        .T_RP_NOPS     (T_RP_NOPS),
        .T_MRD_NOPS    (T_MRD_NOPS),
        .T_RFC_NOPS    (T_RFC_NOPS),
        .DLL_LOCK_NOPS (DLL_LOCK_NOPS),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .supplies_ok (supplies_ok),
        .tmr_last    (tmr_last),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .step        (step),
        .issue       (issue)
    );

    ddr_cmd_encoder #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .issue     (issue),
        .mode      (mode),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .init_done (init_done)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!cke && !init_done && cs_n)); // R1
endmodule

// File: tb/tb_ddr_pwrup_seq.sv
module tb_ddr_pwrup_seq;
    localparam int PW   = 20;
    localparam int RP   = 2;
    localparam int MRD  = 2;
    localparam int RFC  = 6;
    localparam int LOCK = 200;
    localparam int AW   = 13;
    localparam logic [3:0] NOP = 4'b0111, DES = 4'b1111, PRE = 4'b0010,
                           REF = 4'b0001, MRS = 4'b0000;

    logic clk = 1'b0, rst = 1'b1, supplies_ok = 1'b0, interleave = 1'b0;
    logic [2:0] bl_code = 3'd0, cl_code = 3'd0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0] ba;
    logic [AW-1:0] addr;
    logic [3:0] cmd;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always #10 clk = ~clk;

    ddr_pwrup_seq #(
        .ADDR_W(AW), .BA_W(2), .PWRUP_CYC(PW), .T_RP_NOPS(RP),
        .T_MRD_NOPS(MRD), .T_RFC_NOPS(RFC), .DLL_LOCK_NOPS(LOCK)
    ) dut (
        .clk(clk), .rst(rst), .supplies_ok(supplies_ok), .bl_code(bl_code),
        .interleave(interleave), .cl_code(cl_code), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .init_done(init_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        supplies_ok = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: state on the first cycle after reset
        chk(!cke && cmd == DES && !init_done, "R1", "reset state",
            {cke, cmd, init_done}, {1'b0, DES, 1'b0});
    endtask

    task automatic expect_step(input int gap, input logic [3:0] ec,
                               input logic [1:0] eb, input logic [AW-1:0] ea,
                               input string req);
        int nop_bad = 0;
        for (int i = 1; i < gap; i++) begin
            @(negedge clk);
            if (cmd != NOP || !cke || init_done) nop_bad++;
        end
        chk(nop_bad == 0, req, "gap cycles not NOP", nop_bad, 0);
        @(negedge clk);
        chk(cmd == ec && cke, req, "command", {cke, cmd}, {1'b1, ec});
        chk(ba == eb, req, "bank", ba, eb);
        chk(addr == ea, req, "address", addr, ea);
    endtask

    task automatic full_run(input logic [2:0] bl, input logic bt, input logic [2:0] cl);
        int low_cnt = 0;
        int tail_bad = 0;
        logic [AW-1:0] mode_w, dll_w;
        do_reset();
        bl_code = bl; interleave = bt; cl_code = cl;
        mode_w = AW'({cl, bt, bl});
        dll_w  = mode_w | (AW'(1) << 8);
        repeat (5) @(negedge clk);
        // R2: supplies not yet stable keeps CKE low and bus deselected
        chk(!cke && cmd == DES, "R2", "idle before supplies", {cke, cmd}, {1'b0, DES});
        supplies_ok = 1'b1;
        for (int i = 0; i < PW + 50; i++) begin
            @(negedge clk);
            if (cke) break;
            low_cnt++;
        end
        chk(low_cnt == PW + 1, "R2", "cke low cycles", low_cnt, PW + 1);
        chk(cmd == NOP, "R3", "first cke-high command", cmd, NOP);
        expect_step(1,        PRE, 2'd0, AW'(1) << 10, "R3");
        expect_step(RP + 1,   MRS, 2'd1, '0,           "R4");
        expect_step(MRD + 1,  MRS, 2'd0, dll_w,        "R5");
        expect_step(LOCK + 1, PRE, 2'd0, AW'(1) << 10, "R6");
        expect_step(RP + 1,   REF, 2'd0, '0,           "R7");
        expect_step(RFC + 1,  REF, 2'd0, '0,           "R7");
        expect_step(RFC + 1,  MRS, 2'd0, mode_w,       "R8");
        for (int i = 0; i < MRD; i++) begin
            @(negedge clk);
            if (init_done || cmd != NOP) tail_bad++;
        end
        chk(tail_bad == 0, "R9", "done early or not NOP", tail_bad, 0);
        @(negedge clk);
        chk(init_done == 1'b1, "R9", "init_done rise", init_done, 1);
        tail_bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!init_done || !cke || cmd != NOP) tail_bad++;
        end
        chk(tail_bad == 0, "R9", "done not held idle", tail_bad, 0);
    endtask

    initial begin
        int cls[3] = '{2, 5, 6};
        for (int b = 1; b <= 3; b++)
            for (int t = 0; t <= 1; t++)
                for (int c = 0; c < 3; c++)
                    full_run(3'(b), 1'(t), 3'(cls[c]));
        // R1: reset inside the DLL lock window restarts the sequence
        do_reset();
        supplies_ok = 1'b1;
        repeat (PW + 40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!cke && cmd == DES && !init_done, "R1", "mid-sequence reset",
            {cke, cmd, init_done}, {1'b0, DES, 1'b0});
        full_run(3'd2, 1'b1, 3'd5);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule